// File: doc/BRIEF.md
# Biphase Mark Serializing Line Encoder

This block takes transport-stream bytes presented in parallel with a valid flag and sends them out one bit at a time, most significant bit first, on a single biphase-mark-coded line. It runs from one fast clock at twice the bit rate. An internal phase flop splits every bit cell into two halves and acts as a clock enable, so there is no derived clock. The line changes level at the start of every cell. It changes level a second time in the middle of the cell when the bit is a one. A run of zeros therefore still produces one edge per cell, and a receiver can recover the clock from the line.

No ready signal goes back to the source. The source must offer a new byte at each byte boundary, once every eight bit cells (sixteen fast-clock cycles), and hold valid high for a continuous stream. At the nominal rate the bit rate is 19.39265846 Mb/s, the fast clock is about 38.8 MHz and the byte rate is about 2.42 MHz. If valid is low at a boundary, the encoder goes idle and the line holds its level until a byte is accepted.

Top module: `bmc_line_encoder`

## Requirements
- R1: While reset (synchronous, active high) is asserted, and on the first cycle after it, `lineOut` is 0 whatever `byteValid` and `byteIn` carry. After reset the encoder is idle.
- R2: `lineOut` changes level at the start of every bit cell being sent, whatever the value of the bit.
- R3: In the middle of a bit cell, `lineOut` changes level a second time if the bit is 1 and keeps its level if the bit is 0.
- R4: An accepted byte is sent as eight consecutive bit cells of two clock cycles each, most significant bit first. The first cell begins on the clock edge that accepts the byte.
- R5: A byte is accepted only at a byte boundary, on a cell-start edge with `byteValid` high. Values on `byteIn` at every other edge have no effect on the line.
- R6: If `byteValid` is low at a byte boundary, `lineOut` holds its level with no transitions until a byte is accepted.
- R7: While the encoder is idle, a `byteValid` pulse that falls only on a mid-cell edge (the second clock of a cell period) is ignored, and the line stays flat.
- R8: When `byteValid` is high at the boundary that ends a byte, the first cell of the next byte follows the last cell of the previous byte with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast transmitter clock at twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| byteIn | input | DATA_W | Parallel byte to be serialized |
| byteValid | input | 1 | Qualifies `byteIn` at a byte boundary |
| lineOut | output | 1 | Biphase-mark-coded serial line |

## Verification
The assertions assume the source changes `byteIn` and `byteValid` only between clock edges and that reset is held for at least one edge at start-up. They also assume that every cell-start edge lands on an even cycle counted from the release of reset. The stimulus drives all inputs on the falling edge. It makes every byte offer, idle gap and valid pulse an even number of cycles long, so cell phase is never lost. During streaming it keeps `byteValid` high on every edge and shows the bitwise complement of the current byte between boundaries. This proves that only the boundary edge samples the data.

// File: rtl/bmc_enc_pkg.sv
package bmc_enc_pkg;

  // Strobes issued by the control path to the datapath, one clock wide.
  typedef struct packed {
    logic load;       // capture a new byte into the shifter
    logic shift;      // advance to the next bit of the current byte
    logic cellStart;  // a bit cell begins on this edge
    logic midCell;    // second half of a cell begins on this edge
    logic clear;      // byte boundary reached with no data: go idle
  } encStrobes_t;

endpackage

// File: rtl/bmc_enc_ctrl.sv
module bmc_enc_ctrl
  import bmc_enc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        byteValid,
  output encStrobes_t strb
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic             halfPhase;  // 0: first half of a cell, 1: second half
  logic [CNT_W-1:0] bitIdx;

  logic cellEdge, atLast, doLoad, doAdvance, doIdle;

  assign cellEdge  = ~halfPhase;
  assign atLast    = (bitIdx == LAST_IDX);
  assign doLoad    = cellEdge && atLast && byteValid;
  assign doAdvance = cellEdge && !atLast;
  assign doIdle    = cellEdge && atLast && !byteValid;

  // Toggle flop: divides the fast clock to pace the bit cells.
  always_ff @(posedge clk) begin
    if (rst) halfPhase <= 1'b0;
    else     halfPhase <= ~halfPhase;
  end

  // Bit position; parks at the last index so the block idles until data.
  always_ff @(posedge clk) begin
    if (rst)            bitIdx <= LAST_IDX;
    else if (doLoad)    bitIdx <= '0;
    else if (doAdvance) bitIdx <= bitIdx + 1'b1;
  end

  always_comb begin
    strb.load      = doLoad;
    strb.shift     = doAdvance;
    strb.cellStart = doLoad || doAdvance;
    strb.midCell   = halfPhase;
    strb.clear     = doIdle;
  end

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.load, strb.shift, strb.clear}));

  // R5
  load_then_mid_chk: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> (strb.midCell && !strb.cellStart));

endmodule

// File: rtl/bmc_enc_datapath.sv
module bmc_enc_datapath
  import bmc_enc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] byteIn,
  input  encStrobes_t       strb,
  output logic              lineOut
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] shiftReg;
  logic              lineQ;

  // Parallel-load, shift-left register; cleared when idle so no mid-cell edge.
  always_ff @(posedge clk) begin
    if (rst)             shiftReg <= '0;
    else if (strb.load)  shiftReg <= byteIn;
    else if (strb.shift) shiftReg <= {shiftReg[MSB-1:0], 1'b0};
    else if (strb.clear) shiftReg <= '0;
  end

  // Line flop: flips at each cell start, and mid-cell for a one.
  always_ff @(posedge clk) begin
    if (rst)
      lineQ <= 1'b0;
    else if (strb.cellStart || (strb.midCell && shiftReg[MSB]))
      lineQ <= ~lineQ;
  end

  assign lineOut = lineQ;

  // R1
  reset_low_chk: assert property (@(posedge clk)
    rst |=> !lineOut);

  // R2
  cell_edge_chk: assert property (@(posedge clk) disable iff (rst)
    strb.cellStart |=> (lineOut != $past(lineOut)));

endmodule

// File: rtl/bmc_line_encoder.sv
module bmc_line_encoder
  import bmc_enc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] byteIn,
  input  logic              byteValid,
  output logic              lineOut
);

  encStrobes_t strb;

  bmc_enc_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .byteValid (byteValid),
    .strb      (strb)
  );

  bmc_enc_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .byteIn  (byteIn),
    .strb    (strb),
    .lineOut (lineOut)
  );

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    strb.clear |=> $stable(lineOut));

endmodule

// File: tb/bmc_line_encoder_tb_top.sv
module bmc_line_encoder_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       byteValid;
  logic [7:0] byteIn;
  logic       lineOut;

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;
  logic lastLine;

  always #2 clk = ~clk;

  bmc_line_encoder #(.DATA_W(8)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .byteIn    (byteIn),
    .byteValid (byteValid),
    .lineOut   (lineOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One byte offered at a boundary, then complement shown with valid high.
  task automatic sendByte(input logic [7:0] b, input bit chained);
    logic       h[16];
    logic [7:0] dec;
    for (int c = 0; c < 16; c++) begin
      byteValid = 1'b1;
      byteIn    = (c == 0) ? b : ~b;
      @(negedge clk);
      h[c] = lineOut;
    end
    if (chained) chk(h[0] != lastLine, "R8 next byte starts at once", h[0], !lastLine);
    for (int k = 0; k < 8; k++) begin
      logic prev;
      prev = (k == 0) ? lastLine : h[2*k-1];
      chk(h[2*k] != prev, "R2 cell-start edge", h[2*k], !prev);
      chk((h[2*k+1] != h[2*k]) == b[7-k], "R3 mid-cell edge vs bit",
          h[2*k+1] != h[2*k], b[7-k]);
      dec[7-k] = h[2*k+1] != h[2*k];
    end
    chk(dec == b, "R4 R5 decoded byte msb first", dec, b);
    lastLine = h[15];
  endtask

  // Idle cycles; with oddPulse, valid is raised only on mid-cell edges.
  task automatic idleRun(input int n, input bit oddPulse);
    for (int c = 0; c < n; c++) begin
      byteValid = oddPulse && (c % 2 == 1);
      byteIn    = 8'hFF;
      @(negedge clk);
      if (oddPulse) chk(lineOut == lastLine, "R7 mid-cell valid ignored", lineOut, lastLine);
      else          chk(lineOut == lastLine, "R6 idle line holds", lineOut, lastLine);
    end
  endtask

  initial begin
    rst       = 1'b1;
    byteValid = 1'b1;
    byteIn    = 8'hFF;
    repeat (3) begin
      @(negedge clk);
      chk(lineOut == 1'b0, "R1 line low in reset", lineOut, 0);
    end
    rst      = 1'b0;
    lastLine = 1'b0;
    byteValid = 1'b0;
    @(negedge clk);
    chk(lineOut == 1'b0, "R1 line low after reset", lineOut, 0);
    byteValid = 1'b1;
    @(negedge clk);
    // one more cycle keeps even alignment: two edges used since reset
    lastLine = lineOut;
    idleRun(6, 1'b0);
    idleRun(8, 1'b1);
    sendByte(8'h00, 1'b0);
    for (int i = 1; i < 256; i++) sendByte(8'(i), 1'b1);
    idleRun(6, 1'b0);
    sendByte(8'hFF, 1'b0);
    sendByte(8'h5A, 1'b1);
    idleRun(4, 1'b1);
    sendByte(8'h81, 1'b0);
    idleRun(2, 1'b0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule